// File: doc/BRIEF.md
# Masked Register Initialization Sequencer

This block is a bus master that brings up a two-lane serial PHY with no software in the loop. After a start strobe it runs a fixed program held in an internal ROM. Most program steps are masked read-modify-write updates: the engine reads a register, keeps the bits outside the mask and puts in the step's value where the mask is set. Other steps are plain writes, a conditional skip, a timed wait and a bounded poll of two PLL-lock status bits. The ROM builds the per-lane part of the program from one lane template. Lane L's copy is shifted up by L times 0x200 in the address map.

The first step checks whether the PHY is already running. If so, the engine pulses a power-on-reset bit before it programs anything. The engine disables the PLL and programs the two clock units, both lanes, the common lane and the driver coefficients. It then releases the PHY reset, enables the PLL and writes each lane's rate word. Next it polls for lock, and once lock is seen it enables the port. The bus carries one transaction at a time: a request stays up until the target answers with a one-cycle acknowledge. A microsecond prescaler, derived from the parameter `CYC_PER_US`, times the reset wait and the lock timeout.

The FSM states are as follows. IDLE waits for start. FETCH decodes the current ROM step and sends it to RD (for a masked update or a condition), WR (for a plain write), WAIT, POLL_A, or back to IDLE with done (at the end of the program). RD goes to WR on acknowledge for a masked update, or to FETCH for a condition. WR goes to FETCH on acknowledge. WAIT goes to FETCH after the reset wait. POLL_A always goes to POLL_B. POLL_B goes to FETCH when both lock bits are set, to IDLE with timeout once the limit has passed, and back to POLL_A otherwise.

Top module: `phy_init_seq`

## Requirements
- R1: After reset, busy, done, timeout and bus_req are all 0.
- R2: A masked step performs one read and then one write to the same address, and the written word is (old AND NOT mask) OR (value AND mask). The reset-release step at 0xA00 uses value 0x1F and mask 0xFF, so it keeps bits 31:8.
- R3: If bits 4:0 of the word read at 0xA00 are nonzero, the first two writes go to 0x1FD0. The first sets bit 29 and the second clears it, and both keep the other bits. Each write is followed by a wait of at least RST_WAIT_US microseconds. If those bits are zero, 0x1FD0 is never accessed.
- R4: The first write after the optional pre-reset is 0x88000000 to 0x1FF4. The last four writes before polling are, in order: the reset release at 0xA00, 0xEE000000 to 0x1FF4, and 0xE0E9E038 to 0x1FE0 and then to 0x1FE4. A full run issues 29 writes, or 31 with the pre-reset.
- R5: The five lane-template writes for lane 1 go to the lane-0 addresses plus 0x200, in the same order. They directly follow the lane-0 writes.
- R6: Each lane's template ends by clearing bit 4 at lane offset 0x380 and bit 9 at lane offset 0x3C0, and it keeps all other bits.
- R7: The engine reads bit 4 of 0x8114 and then bit 4 of 0x8214, and repeats, until both are set. Only after that does it write 0x03 to 0x800C as its final write.
- R8: If lock is not seen within LOCK_TIMEOUT_US microseconds from the start of polling, timeout rises, busy falls and 0x800C is not written. Timeout stays high until the next start, which clears it.
- R9: On success, done is high for exactly one cycle, with busy low in that cycle.
- R10: A start strobe received while busy is ignored: the run is not restarted and only one done follows.
- R11: While bus_req is high and bus_ack is low, bus_req, bus_we, bus_addr and bus_wdata hold their values into the next cycle.
- R12: A start while idle makes busy high from the next cycle until done or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe; ignored while busy |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | Sticky lock-timeout flag, cleared by start |
| bus_req | output | 1 | Transaction request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge; read data is valid with it |
| bus_rdata | input | 32 | Read data |

## Verification
The bench fills the registers the engine touches with random contents. This shows whether each masked update keeps exactly the bits outside its mask, and whether the values being cleared or set were really read first. Runs with bits 4:0 of 0xA00 zero and nonzero separate the plain path from the pre-reset path, including the wait gaps between writes. Lock bits that arrive early, late, one after the other, or never, separate repeated polling, the final port write and the sticky timeout. Random acknowledge latency and a second start in mid-run test that requests are held and that restarts are ignored.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;

    localparam int AW          = 16;
    localparam int DW          = 32;
    localparam int LANES       = 2;
    localparam int LANE_STRIDE = 32'h200;
    localparam int LOCK_BIT    = 4;

    typedef enum logic [2:0] {K_RMW, K_WRITE, K_COND, K_WAIT, K_POLL, K_END} op_kind_e;

    typedef struct packed {
        op_kind_e        kind;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        logic [DW-1:0]   mask;
    } step_t;

    localparam logic [AW-1:0] A_COMLANE = 16'h0A00;
    localparam logic [AW-1:0] A_CPUCTL  = 16'h1FD0;
    localparam logic [AW-1:0] A_PLLCTL  = 16'h1FF4;
    localparam logic [AW-1:0] A_RATE    = 16'h1FE0;
    localparam logic [AW-1:0] A_STAT0   = 16'h8114;
    localparam logic [AW-1:0] A_STAT1   = 16'h8214;
    localparam logic [AW-1:0] A_PORTCTL = 16'h800C;
    localparam logic [DW-1:0] POR_MASK  = 32'h2000_0000;
    localparam logic [DW-1:0] RATE_WORD = 32'hE0E9_E038;

    localparam int CMU_LEN    = 3;
    localparam int LANE_LEN   = 5;
    localparam int COM_LEN    = 3;
    localparam int COEF_LEN   = 2;
    localparam int PC_COND    = 0;
    localparam int PC_PLL_OFF = 5;
    localparam int PC_CMU0    = PC_PLL_OFF + 1;
    localparam int PC_CMU1    = PC_CMU0 + CMU_LEN;
    localparam int PC_LANE    = PC_CMU1 + CMU_LEN;
    localparam int PC_COM     = PC_LANE + LANES * LANE_LEN;
    localparam int PC_COEF    = PC_COM + COM_LEN;
    localparam int PC_REL     = PC_COEF + LANES * COEF_LEN;
    localparam int PC_PLL_ON  = PC_REL + 1;
    localparam int PC_RATE    = PC_PLL_ON + 1;
    localparam int PC_POLL    = PC_RATE + LANES;
    localparam int PC_PORT    = PC_POLL + 1;
    localparam int PC_END     = PC_PORT + 1;
    localparam int PROG_LEN   = PC_END + 1;
    localparam int PC_W       = $clog2(PROG_LEN);

    function automatic step_t mk(op_kind_e k, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] m);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.data = d;
        s.mask = m;
        return s;
    endfunction

    // clock-unit template; unit 1 sits 0xC00 above unit 0
    function automatic step_t cmu_entry(int unit, int k);
        logic [AW-1:0] base;
        base = (unit != 0) ? 16'h0C00 : 16'h0000;
        case (k)
            0:       return mk(K_RMW, base + 16'h0004, (unit != 0) ? 32'h22 : 32'h11, 32'h0000_00FF);
            1:       return mk(K_RMW, base + 16'h0010, (unit != 0) ? 32'h5500 : 32'h2A00, 32'h0000_FF00);
            default: return mk(K_RMW, base, 32'h0000_0003, 32'h0000_00FF);
        endcase
    endfunction

    // lane template for lane 0; auto-negotiation and training disables last
    function automatic step_t lane_entry(int k);
        case (k)
            0:       return mk(K_RMW, 16'h0204, 32'h0000_0040, 32'h0000_00FF);
            1:       return mk(K_RMW, 16'h0210, 32'h0012_0000, 32'h00FF_0000);
            2:       return mk(K_RMW, 16'h0230, 32'h0000_1C00, 32'h0000_FF00);
            3:       return mk(K_RMW, 16'h0380, 32'h0,         32'h0000_0010);
            default: return mk(K_RMW, 16'h03C0, 32'h0,         32'h0000_0200);
        endcase
    endfunction

    function automatic step_t com_entry(int k);
        case (k)
            0:       return mk(K_RMW, 16'h0A84, 32'h0000_0000, 32'h0000_00FF);
            1:       return mk(K_RMW, 16'h0A90, 32'h6660_0000, 32'hFFF0_0000);
            default: return mk(K_RMW, 16'h0B10, 32'h9C00_0000, 32'hFF00_0000);
        endcase
    endfunction

    function automatic step_t coef_entry(int k);
        if (k == 0) return mk(K_RMW, 16'h0208, 32'h0000_0000, 32'h0000_0F1F);
        return mk(K_RMW, 16'h0208, 32'h0000_00A0, 32'h0000_00E0);
    endfunction

    function automatic step_t seq_step(logic [PC_W-1:0] pc);
        int    i;
        step_t s;
        i = int'(pc);
        s = mk(K_END, '0, '0, '0);
        if (i == PC_COND)
            s = mk(K_COND, A_COMLANE, DW'(PC_PLL_OFF - PC_COND), 32'h0000_001F);
        else if (i == 1)
            s = mk(K_RMW, A_CPUCTL, POR_MASK, POR_MASK);
        else if (i == 3)
            s = mk(K_RMW, A_CPUCTL, 32'h0, POR_MASK);
        else if (i == 2 || i == 4)
            s = mk(K_WAIT, '0, '0, '0);
        else if (i == PC_PLL_OFF)
            s = mk(K_WRITE, A_PLLCTL, 32'h8800_0000, '1);
        else if (i >= PC_CMU0 && i < PC_LANE)
            s = cmu_entry((i - PC_CMU0) / CMU_LEN, (i - PC_CMU0) % CMU_LEN);
        else if (i >= PC_LANE && i < PC_COM) begin
            s = lane_entry((i - PC_LANE) % LANE_LEN);
            s.addr = s.addr + AW'(((i - PC_LANE) / LANE_LEN) * LANE_STRIDE);
        end
        else if (i >= PC_COM && i < PC_COEF)
            s = com_entry(i - PC_COM);
        else if (i >= PC_COEF && i < PC_REL) begin
            s = coef_entry((i - PC_COEF) % COEF_LEN);
            s.addr = s.addr + AW'(((i - PC_COEF) / COEF_LEN) * LANE_STRIDE);
        end
        else if (i == PC_REL)
            s = mk(K_RMW, A_COMLANE, 32'h0000_001F, 32'h0000_00FF);
        else if (i == PC_PLL_ON)
            s = mk(K_WRITE, A_PLLCTL, 32'hEE00_0000, '1);
        else if (i >= PC_RATE && i < PC_POLL)
            s = mk(K_WRITE, A_RATE + AW'(4 * (i - PC_RATE)), RATE_WORD, '1);
        else if (i == PC_POLL)
            s = mk(K_POLL, A_STAT0, DW'(A_STAT1), '0);
        else if (i == PC_PORT)
            s = mk(K_WRITE, A_PORTCTL, 32'h0000_0003, '1);
        return s;
    endfunction

endpackage

// File: rtl/phy_init_rom.sv
module phy_init_rom
    import phy_init_pkg::*;
(
    input  logic [PC_W-1:0] pc,
    output step_t           step
);

    always_comb step = seq_step(pc);

endmodule

// File: rtl/phy_init_ustick.sv
module phy_init_ustick #(
    parameter int CYC_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(CYC_PER_US - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
    import phy_init_pkg::*;
#(
    parameter int CYC_PER_US      = 100,
    parameter int RST_WAIT_US     = 50,
    parameter int LOCK_TIMEOUT_US = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);

    localparam int UMAX = (LOCK_TIMEOUT_US > RST_WAIT_US) ? LOCK_TIMEOUT_US : RST_WAIT_US;
    localparam int UW   = $clog2(UMAX + 2);

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_WAIT, S_POLL_A, S_POLL_B} state_e;

    state_e          state;
    logic [PC_W-1:0] pc;
    logic [DW-1:0]   wdata_q;
    logic            lock_a_q;
    logic [UW-1:0]   ucnt;
    logic            done_q;
    logic            tmo_q;
    logic            tick;
    step_t           step;

    phy_init_rom u_rom (.pc(pc), .step(step));

    phy_init_ustick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == S_FETCH),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            pc       <= '0;
            wdata_q  <= '0;
            lock_a_q <= 1'b0;
            ucnt     <= '0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick && ucnt != {UW{1'b1}} &&
                (state == S_WAIT || state == S_POLL_A || state == S_POLL_B))
                ucnt <= ucnt + 1'b1;
            unique case (state)
                S_IDLE: if (start) begin
                    pc    <= '0;
                    tmo_q <= 1'b0;
                    state <= S_FETCH;
                end
                S_FETCH: begin
                    ucnt <= '0;
                    unique case (step.kind)
                        K_RMW, K_COND: state <= S_RD;
                        K_WRITE: begin
                            wdata_q <= step.data;
                            state   <= S_WR;
                        end
                        K_WAIT:  state <= S_WAIT;
                        K_POLL:  state <= S_POLL_A;
                        default: begin
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end
                    endcase
                end
                S_RD: if (bus_ack) begin
                    if (step.kind == K_COND) begin
                        pc    <= ((bus_rdata & step.mask) == '0) ? pc + step.data[PC_W-1:0] : pc + 1'b1;
                        state <= S_FETCH;
                    end else begin
                        wdata_q <= (bus_rdata & ~step.mask) | (step.data & step.mask);
                        state   <= S_WR;
                    end
                end
                S_WR: if (bus_ack) begin
                    pc    <= pc + 1'b1;
                    state <= S_FETCH;
                end
                S_WAIT: if (tick && ucnt == UW'(RST_WAIT_US - 1)) begin
                    pc    <= pc + 1'b1;
                    state <= S_FETCH;
                end
                S_POLL_A: if (bus_ack) begin
                    lock_a_q <= bus_rdata[LOCK_BIT];
                    state    <= S_POLL_B;
                end
                S_POLL_B: if (bus_ack) begin
                    if (lock_a_q && bus_rdata[LOCK_BIT]) begin
                        pc    <= pc + 1'b1;
                        state <= S_FETCH;
                    end else if (ucnt >= UW'(LOCK_TIMEOUT_US)) begin
                        tmo_q <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        state <= S_POLL_A;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = (state == S_RD) || (state == S_WR) || (state == S_POLL_A) || (state == S_POLL_B);
        bus_we    = (state == S_WR);
        bus_addr  = (state == S_POLL_B) ? step.data[AW-1:0] : step.addr;
        bus_wdata = wdata_q;
        busy      = (state != S_IDLE);
        done      = done_q;
        timeout   = tmo_q;
    end

endmodule

// File: rtl/phy_init_chk.sv
module phy_init_chk
    import phy_init_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          timeout,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ack,
    input logic [DW-1:0] bus_rdata
);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout && !start |=> timeout);

    assert_tmo_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !busy && !bus_req);

    assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !timeout);

endmodule

bind phy_init_seq phy_init_chk u_chk (.*);

// File: tb/sim_phy_init_seq.sv
module sim_phy_init_seq;
    import phy_init_pkg::*;

    localparam int CLK_NS = 10;
    localparam int CPU    = 2;
    localparam int RWU    = 20;
    localparam int LTU    = 300;
    localparam int NEVER  = 1 << 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, timeout, bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #(CLK_NS / 2) clk = ~clk;

    phy_init_seq #(.CYC_PER_US(CPU), .RST_WAIT_US(RWU), .LOCK_TIMEOUT_US(LTU)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .timeout(timeout),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0, start_cyc = 0, dly_a = NEVER, dly_b = NEVER, done_cnt = 0, lat = 0;
    logic [31:0] mem [int];
    logic [31:0] pre [int];
    int          ev_addr [$];
    logic [31:0] ev_data [$];
    bit          ev_we   [$];
    int          ev_cyc  [$];

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pv(int a);
        return pre.exists(a) ? pre[a] : 32'h0;
    endfunction

    function automatic logic [31:0] rd_val(int a);
        if (a == int'(A_STAT0)) return ((cyc - start_cyc) >= dly_a) ? 32'h10 : 32'h0;
        if (a == int'(A_STAT1)) return ((cyc - start_cyc) >= dly_b) ? 32'h10 : 32'h0;
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // register-file and status model with random acknowledge latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            bus_ack <= 1'b0;
            lat     <= 0;
        end else begin
            bus_ack <= 1'b0;
            if (done) done_cnt++;
            if (bus_req && !bus_ack) begin
                if (lat > 0) lat <= lat - 1;
                else begin
                    lat     <= $urandom_range(0, 2);
                    bus_ack <= 1'b1;
                    ev_addr.push_back(int'(bus_addr));
                    ev_we.push_back(bus_we);
                    ev_cyc.push_back(cyc);
                    if (bus_we) begin
                        mem[int'(bus_addr)] = bus_wdata;
                        ev_data.push_back(bus_wdata);
                    end else begin
                        bus_rdata <= rd_val(int'(bus_addr));
                        ev_data.push_back(rd_val(int'(bus_addr)));
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check_run(bit por, bit ok, bit poke);
        int wa[$];
        logic [31:0] wd[$];
        int wc[$];
        int b, e, i0, i1, first_poll, n_stat0, port_w;
        logic [31:0] a00;
        for (int i = 0; i < ev_addr.size(); i++)
            if (ev_we[i]) begin
                wa.push_back(ev_addr[i]); wd.push_back(ev_data[i]); wc.push_back(ev_cyc[i]);
            end
        chk(wa.size() == 28 + (ok ? 1 : 0) + (por ? 2 : 0), "R4", "write count",
            wa.size(), 28 + (ok ? 1 : 0) + (por ? 2 : 0));
        b = por ? 2 : 0;
        if (por) begin
            chk(wa[0] == 'h1FD0 && wd[0] == (pv('h1FD0) | 32'h2000_0000), "R3", "por set",
                wd[0], pv('h1FD0) | 32'h2000_0000);
            chk(wa[1] == 'h1FD0 && wd[1] == (pv('h1FD0) & ~32'h2000_0000), "R3", "por clear",
                wd[1], pv('h1FD0) & ~32'h2000_0000);
            chk(wc[1] - wc[0] >= RWU * CPU && wc[2] - wc[1] >= RWU * CPU, "R3", "por wait gaps",
                wc[1] - wc[0], RWU * CPU);
        end else begin
            int n = 0;
            foreach (ev_addr[i]) if (ev_addr[i] == 'h1FD0) n++;
            chk(n == 0, "R3", "no 0x1FD0 access", n, 0);
        end
        chk(wa[b] == 'h1FF4 && wd[b] == 32'h8800_0000, "R4", "pll off first", wd[b], 32'h8800_0000);
        e = b + 27;
        chk(wa[e-3] == 'hA00 && wa[e-2] == 'h1FF4 && wd[e-2] == 32'hEE00_0000, "R4", "release then pll on",
            wd[e-2], 32'hEE00_0000);
        chk(wa[e-1] == 'h1FE0 && wa[e] == 'h1FE4 && wd[e-1] == RATE_WORD && wd[e] == RATE_WORD, "R4",
            "lane rate words", wd[e], RATE_WORD);
        a00 = (pv('hA00) & ~32'hFF) | 32'h1F;
        chk(mem['hA00] == a00, "R2", "0xA00 masked release", mem['hA00], a00);
        for (int i = 1; i < ev_addr.size(); i++)
            if (ev_we[i] && ev_addr[i] == 'hA00)
                chk(!ev_we[i-1] && ev_addr[i-1] == 'hA00 && ev_data[i-1] == pv('hA00), "R2",
                    "read precedes write", ev_data[i-1], pv('hA00));
        i0 = -1; i1 = -1;
        foreach (wa[i]) begin
            if (wa[i] == 'h380) i0 = i;
            if (wa[i] == 'h580) i1 = i;
        end
        chk(i0 >= 3 && i1 - i0 == 5, "R5", "lane 1 follows lane 0", i1 - i0, 5);
        if (i0 >= 3 && i1 - i0 == 5)
            for (int j = 0; j < 5; j++)
                chk(wa[i1-3+j] == wa[i0-3+j] + 'h200, "R5", "lane 1 address", wa[i1-3+j], wa[i0-3+j] + 'h200);
        for (int l = 0; l < 2; l++) begin
            chk(mem['h380 + l * 'h200] == (pv('h380 + l * 'h200) & ~32'h10), "R6", "autoneg bit cleared",
                mem['h380 + l * 'h200], pv('h380 + l * 'h200) & ~32'h10);
            chk(mem['h3C0 + l * 'h200] == (pv('h3C0 + l * 'h200) & ~32'h200), "R6", "training bit cleared",
                mem['h3C0 + l * 'h200], pv('h3C0 + l * 'h200) & ~32'h200);
        end
        n_stat0 = 0; first_poll = -1; port_w = 0;
        foreach (ev_addr[i]) begin
            if (ev_addr[i] == int'(A_STAT0)) begin
                n_stat0++;
                if (first_poll < 0) first_poll = ev_cyc[i];
            end
            if (ev_we[i] && ev_addr[i] == int'(A_PORTCTL)) port_w++;
        end
        if (ok) begin
            int lk;
            lk = (dly_a > dly_b) ? dly_a : dly_b;
            chk(wa[wa.size()-1] == int'(A_PORTCTL) && wd[wd.size()-1] == 32'h3, "R7", "port enable last",
                wd[wd.size()-1], 32'h3);
            chk(wc[wc.size()-1] >= start_cyc + lk, "R7", "port enable after lock", wc[wc.size()-1], start_cyc + lk);
            chk(n_stat0 >= 1 && !ev_we[ev_addr.size()-2] && ev_addr[ev_addr.size()-2] == int'(A_STAT1), "R7",
                "poll both status words", ev_addr[ev_addr.size()-2], A_STAT1);
            chk(done_cnt == 1 && !timeout, "R9", "single done", done_cnt, 1);
            if (poke) chk(done_cnt == 1, "R10", "start while busy ignored", done_cnt, 1);
        end else begin
            chk(timeout && !busy && done_cnt == 0, "R8", "timeout raised", timeout, 1);
            chk(port_w == 0, "R8", "no port enable", port_w, 0);
            chk(ev_cyc[ev_cyc.size()-1] - first_poll >= (LTU - 1) * CPU, "R8", "poll duration",
                ev_cyc[ev_cyc.size()-1] - first_poll, (LTU - 1) * CPU);
            repeat (30) @(negedge clk);
            chk(timeout, "R8", "timeout sticky", timeout, 1);
        end
    endtask

    task automatic run_case(bit por, int da, int db, bit ok, bit poke);
        mem.delete();
        mem['hA00]  = ($urandom & ~32'h1F) | (por ? 32'($urandom_range(1, 31)) : 32'h0);
        mem['h1FD0] = $urandom;
        for (int l = 0; l < 2; l++) begin
            mem['h380 + l * 'h200] = $urandom | 32'h10;
            mem['h3C0 + l * 'h200] = $urandom | 32'h200;
        end
        pre = mem;
        ev_addr.delete(); ev_data.delete(); ev_we.delete(); ev_cyc.delete();
        done_cnt = 0;
        dly_a = da;
        dly_b = db;
        @(negedge clk);
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !timeout, "R12", "busy after start, timeout cleared", {busy, timeout}, 2'b10);
        if (poke) begin
            repeat (15) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R10", "still busy after second start", busy, 1);
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check_run(por, ok, poke);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !timeout && !bus_req, "R1", "reset state",
            {busy, done, timeout, bus_req}, 4'b0000);
        run_case(1'b0, 5, 10, 1'b1, 1'b0);
        run_case(1'b1, 300, 320, 1'b1, 1'b1);
        run_case(1'b0, 100, NEVER, 1'b0, 1'b0);
        run_case(1'b1, 0, 0, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++)
            run_case(1'($urandom_range(0, 1)), $urandom_range(0, 500), $urandom_range(0, 500),
                     1'b1, 1'($urandom_range(0, 1)));
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule